// File: doc/BRIEF.md
# Preset-Mode Raster Timing Controller

This block generates raster timing from a small fixed set of display modes. Software does not program each timing field. It writes a 12-bit mode code into a select register and then arms it by writing a commit key to a separate register. If the code is one the block recognises, the matching geometry is latched and the raster counters restart at the top-left corner. The block then sweeps a horizontal and a vertical counter through that geometry. It also drives an active-video flag, the pixel depth and a line stride, which the downstream fetch logic uses.

Software sees a 32-bit register port. Through it, software sets the pixel depth and a screen-enable bit, reads back whether the raster is in vertical blanking, and controls a vertical-blank interrupt. The interrupt has an enable bit, and any write to the config register clears a pending interrupt. The clock is the pixel clock.

The parameter `GEOM_SHIFT` (default 0) divides every horizontal and vertical count in the mode table by 2^GEOM_SHIFT. This gives a reduced-size raster with the same behaviour. The line stride is not scaled.

Top module: `preset_vtc`

## Requirements
- R1: After reset, hCount and vCount are 0, activeVideo and irq are 0, pixDepth is 0, the screen is disabled, and the latched geometry is that of code 0x101, so lineStride is 80.
- R2: Only bits 11:0 of a register write are stored. Reads at offset 0x0 (mode select), 0x10 (config) and 0x18 (control) return the stored 12 bits. Offset 0x4 stores and returns bits 2:0 only. Offset 0xC reads as 0.
- R3: On each clock, hCount advances by one from 0 to hTotal-1 and then wraps to 0. At each wrap, vCount advances from 0 to vTotal-1 and then wraps to 0.
- R4: A write to offset 0xC whose low 12 bits equal 0x101, made while the select register holds a recognised code, latches that code's geometry. The same clock edge sets hCount and vCount to 0. A write of any other value to 0xC changes nothing.
- R5: The mode table gives active width x height, horizontal total, vertical total and base stride for each code. Codes 0x101 and 0x686: 640x480, 864, 525, 80. Code 0x282: 512x384, 640, 407, 64. Code 0xB8B: 640x480, 800, 525, 80. Code 0x989: 832x624, 1072, 690, 104. All horizontal and vertical counts are shifted right by GEOM_SHIFT.
- R6: A commit made while the select register holds an unrecognised code leaves both the geometry and the counters untouched.
- R7: activeVideo is 1 exactly when hCount < active width, vCount < active height, and the screen-enable bit (bit 7 of offset 0x18) is 1.
- R8: pixDepth equals the stored depth code: 0 is 1 bpp, 1 is 2 bpp, 2 is 4 bpp, 3 is 8 bpp, 4 is 16 bpp. lineStride equals the base stride shifted left by that code. Both take effect one clock after the write.
- R9: A read of offset 0x14 returns 1 in bit 24 when vCount >= active height, and 0 in every other bit.
- R10: When config bit 0 is 1 and the raster sits at hCount 0 on the first line after the active area, the interrupt status is set at the next clock. irq is high while the status is set. A config write on that same clock does not prevent the set.
- R11: Any write to offset 0x10 clears a pending interrupt status, unless R10 sets it on the same clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Register write strobe |
| addr | input | ADDR_W (5) | Register byte offset |
| wrData | input | 32 | Register write data |
| rdData | output | 32 | Register read data (combinational from addr) |
| hCount | output | 11 | Horizontal raster position |
| vCount | output | 11 | Vertical raster position |
| activeVideo | output | 1 | Inside the visible area and screen enabled |
| pixDepth | output | 3 | Pixel depth code for fetch |
| lineStride | output | 16 | Bytes per fetched line |
| irq | output | 1 | Vertical-blank interrupt |

## Verification
The assertions check on every cycle that the counters stay inside the latched totals and advance by one or wrap. They also check that a restart lands on the origin, that a disabled screen never shows active video, and that the interrupt only rises after a blank-entry point while it is enabled and falls after a config write. Only the bench scenarios can show the rest. These are the mapping from each code to its geometry, that a wrong key or an unknown code leaves the raster phase unchanged, the truncation to 12 bits on readback, the stride for every depth, and the race between setting and clearing the interrupt on the same clock.

// File: rtl/vtc_pkg.sv
package vtc_pkg;
  localparam int CNT_W    = 11;
  localparam int STRIDE_W = 16;

  localparam logic [11:0] CODE_VGA_A = 12'h101;
  localparam logic [11:0] CODE_VGA_B = 12'h686;
  localparam logic [11:0] CODE_SMALL = 12'h282;
  localparam logic [11:0] CODE_VGA_C = 12'hB8B;
  localparam logic [11:0] CODE_WIDE  = 12'h989;
  localparam logic [11:0] COMMIT_KEY = 12'h101;

  localparam int OFF_SEL    = 'h00;
  localparam int OFF_DEPTH  = 'h04;
  localparam int OFF_COMMIT = 'h0C;
  localparam int OFF_CFG    = 'h10;
  localparam int OFF_STAT   = 'h14;
  localparam int OFF_CTL    = 'h18;

  typedef struct packed {
    logic [CNT_W-1:0] hAct;
    logic [CNT_W-1:0] hTot;
    logic [CNT_W-1:0] vAct;
    logic [CNT_W-1:0] vTot;
  } timing_t;

  typedef struct packed {
    logic restart;
  } ctlStrobe_t;

  typedef struct packed {
    logic    hit;
    timing_t t;
    logic [7:0] stride;
  } modeHit_t;

  function automatic modeHit_t mkMode(int ha, int ht, int va, int vt, int st, int sh);
    modeHit_t m;
    m.hit    = 1'b1;
    m.t.hAct = CNT_W'(ha >> sh);
    m.t.hTot = CNT_W'(ht >> sh);
    m.t.vAct = CNT_W'(va >> sh);
    m.t.vTot = CNT_W'(vt >> sh);
    m.stride = 8'(st);
    return m;
  endfunction

  function automatic modeHit_t lookupMode(logic [11:0] code, int sh);
    modeHit_t m;
    case (code)
      CODE_VGA_A, CODE_VGA_B: m = mkMode(640, 864, 480, 525, 80, sh);
      CODE_SMALL:             m = mkMode(512, 640, 384, 407, 64, sh);
      CODE_VGA_C:             m = mkMode(640, 800, 480, 525, 80, sh);
      CODE_WIDE:              m = mkMode(832, 1072, 624, 690, 104, sh);
      default: begin
        m     = mkMode(640, 864, 480, 525, 80, sh);
        m.hit = 1'b0;
      end
    endcase
    return m;
  endfunction
endpackage

// File: rtl/vtc_ctrl.sv
module vtc_ctrl
  import vtc_pkg::*;
#(
  parameter int GEOM_SHIFT = 0,
  parameter int ADDR_W     = 5
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wrEn,
  input  logic [ADDR_W-1:0]   addr,
  input  logic [31:0]         wrData,
  input  logic                vblank,
  input  logic                vblankEdge,
  output logic [31:0]         rdData,
  output timing_t             timing,
  output logic [STRIDE_W-1:0] lineStride,
  output logic [2:0]          pixDepth,
  output ctlStrobe_t          strobe,
  output logic                screenEn,
  output logic                irqEn,
  output logic                irq
);
  localparam modeHit_t RESET_MODE = lookupMode(CODE_VGA_A, GEOM_SHIFT);

  logic [11:0] wLow;
  logic [19:0] unusedHi;
  logic [11:0] selReg, cfgReg, ctlReg;
  logic [2:0]  depthReg;
  logic [7:0]  strideQ;
  logic        irqStatus;
  timing_t     timingQ;
  modeHit_t    pending;
  logic        selWr, depthWr, cfgWr, ctlWr, commitGo;

  assign wLow     = wrData[11:0];
  assign unusedHi = wrData[31:12];
  assign pending  = lookupMode(selReg, GEOM_SHIFT);

  assign selWr    = wrEn && (addr == ADDR_W'(OFF_SEL));
  assign depthWr  = wrEn && (addr == ADDR_W'(OFF_DEPTH));
  assign cfgWr    = wrEn && (addr == ADDR_W'(OFF_CFG));
  assign ctlWr    = wrEn && (addr == ADDR_W'(OFF_CTL));
  assign commitGo = wrEn && (addr == ADDR_W'(OFF_COMMIT)) &&
                    (wLow == COMMIT_KEY) && pending.hit;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      selReg    <= '0;
      depthReg  <= '0;
      cfgReg    <= '0;
      ctlReg    <= '0;
      irqStatus <= 1'b0;
      timingQ   <= RESET_MODE.t;
      strideQ   <= RESET_MODE.stride;
    end else begin
      if (selWr)   selReg   <= wLow;
      if (depthWr) depthReg <= wLow[2:0];
      if (cfgWr)   cfgReg   <= wLow;
      if (ctlWr)   ctlReg   <= wLow;
      if (commitGo) begin
        timingQ <= pending.t;
        strideQ <= pending.stride;
      end
      if (vblankEdge && cfgReg[0]) irqStatus <= 1'b1;
      else if (cfgWr)              irqStatus <= 1'b0;
    end
  end

  always_comb begin
    rdData = '0;
    case (addr)
      ADDR_W'(OFF_SEL):   rdData = {20'b0, selReg};
      ADDR_W'(OFF_DEPTH): rdData = {29'b0, depthReg};
      ADDR_W'(OFF_CFG):   rdData = {20'b0, cfgReg};
      ADDR_W'(OFF_STAT):  rdData = {7'b0, vblank, 24'b0};
      ADDR_W'(OFF_CTL):   rdData = {20'b0, ctlReg};
      default:            rdData = '0;
    endcase
  end

  assign timing         = timingQ;
  assign strobe.restart = commitGo;
  assign pixDepth       = depthReg;
  assign lineStride     = STRIDE_W'(strideQ) << depthReg;
  assign screenEn       = ctlReg[7];
  assign irqEn          = cfgReg[0];
  assign irq            = irqStatus;
endmodule

// File: rtl/vtc_dpath.sv
module vtc_dpath
  import vtc_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  timing_t          timing,
  input  ctlStrobe_t       strobe,
  input  logic             screenEn,
  output logic [CNT_W-1:0] hCount,
  output logic [CNT_W-1:0] vCount,
  output logic             activeVideo,
  output logic             vblank,
  output logic             vblankEdge
);
  logic lineEnd, frameEnd;

  assign lineEnd  = hCount >= timing.hTot - CNT_W'(1);
  assign frameEnd = vCount >= timing.vTot - CNT_W'(1);

  always_ff @(posedge clk) begin
    if (!rst_n || strobe.restart) begin
      hCount <= '0;
      vCount <= '0;
    end else if (lineEnd) begin
      hCount <= '0;
      vCount <= frameEnd ? '0 : vCount + CNT_W'(1);
    end else begin
      hCount <= hCount + CNT_W'(1);
    end
  end

  assign vblank      = vCount >= timing.vAct;
  assign vblankEdge  = (hCount == '0) && (vCount == timing.vAct);
  assign activeVideo = screenEn && (hCount < timing.hAct) && (vCount < timing.vAct);
endmodule

// File: rtl/preset_vtc.sv
module preset_vtc
  import vtc_pkg::*;
#(
  parameter int GEOM_SHIFT = 0,
  parameter int ADDR_W     = 5
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wrEn,
  input  logic [ADDR_W-1:0]   addr,
  input  logic [31:0]         wrData,
  output logic [31:0]         rdData,
  output logic [CNT_W-1:0]    hCount,
  output logic [CNT_W-1:0]    vCount,
  output logic                activeVideo,
  output logic [2:0]          pixDepth,
  output logic [STRIDE_W-1:0] lineStride,
  output logic                irq
);
  timing_t    curTiming;
  ctlStrobe_t ctlStrobe;
  logic       screenEn, irqEn, vblank, vblankEdge;

  vtc_ctrl #(.GEOM_SHIFT(GEOM_SHIFT), .ADDR_W(ADDR_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .wrEn(wrEn), .addr(addr), .wrData(wrData),
    .vblank(vblank), .vblankEdge(vblankEdge), .rdData(rdData),
    .timing(curTiming), .lineStride(lineStride), .pixDepth(pixDepth),
    .strobe(ctlStrobe), .screenEn(screenEn), .irqEn(irqEn), .irq(irq)
  );

  vtc_dpath u_dpath (
    .clk(clk), .rst_n(rst_n), .timing(curTiming), .strobe(ctlStrobe),
    .screenEn(screenEn), .hCount(hCount), .vCount(vCount),
    .activeVideo(activeVideo), .vblank(vblank), .vblankEdge(vblankEdge)
  );
endmodule

// File: rtl/vtc_checker.sv
module vtc_checker
  import vtc_pkg::*;
#(
  parameter int ADDR_W = 5
) (
  input logic             clk,
  input logic             rst_n,
  input logic             wrEn,
  input logic [ADDR_W-1:0] addr,
  input logic [CNT_W-1:0] hCount,
  input logic [CNT_W-1:0] vCount,
  input logic             activeVideo,
  input logic             irq,
  input timing_t          timing,
  input ctlStrobe_t       strobe,
  input logic             screenEn,
  input logic             irqEn,
  input logic             vblankEdge
);
  a_r3_h_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    hCount < timing.hTot);

  a_r3_h_step: assert property (@(posedge clk) disable iff (!rst_n)
    (!strobe.restart && hCount < timing.hTot - CNT_W'(1))
    |=> hCount == $past(hCount) + CNT_W'(1));

  a_r3_v_step: assert property (@(posedge clk) disable iff (!rst_n)
    (!strobe.restart && hCount == timing.hTot - CNT_W'(1) && vCount < timing.vTot - CNT_W'(1))
    |=> (hCount == '0) && (vCount == $past(vCount) + CNT_W'(1)));

  a_r4_restart_origin: assert property (@(posedge clk) disable iff (!rst_n)
    strobe.restart |=> (hCount == '0) && (vCount == '0));

  a_r7_blank_gate: assert property (@(posedge clk) disable iff (!rst_n)
    !screenEn |-> !activeVideo);

  a_r10_rise_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $past(irqEn) && $past(vblankEdge));

  a_r11_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (wrEn && addr == ADDR_W'(OFF_CFG) && !vblankEdge) |=> !irq);
endmodule

bind preset_vtc vtc_checker #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .wrEn(wrEn), .addr(addr),
  .hCount(hCount), .vCount(vCount), .activeVideo(activeVideo), .irq(irq),
  .timing(curTiming), .strobe(ctlStrobe), .screenEn(screenEn),
  .irqEn(irqEn), .vblankEdge(vblankEdge)
);

// File: tb/preset_vtc_tb.sv
module preset_vtc_tb;
  localparam int CLK_PERIOD = 10;
  localparam int SH = 3;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wrEn = 1'b0;
  logic [4:0]  addr = '0;
  logic [31:0] wrData = '0;
  logic [31:0] rdData;
  logic [10:0] hCount, vCount;
  logic        activeVideo, irq;
  logic [2:0]  pixDepth;
  logic [15:0] lineStride;

  int nChecks = 0;
  int nErr = 0;
  longint cyc = 0;
  longint cycCommit = 0;
  logic [11:0] curCode = 12'h101;
  int curDepth = 0;
  int curEn = 0;

  preset_vtc #(.GEOM_SHIFT(SH), .ADDR_W(5)) u_dut (
    .clk(clk), .rst_n(rst_n), .wrEn(wrEn), .addr(addr), .wrData(wrData),
    .rdData(rdData), .hCount(hCount), .vCount(vCount), .activeVideo(activeVideo),
    .pixDepth(pixDepth), .lineStride(lineStride), .irq(irq)
  );

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  function automatic int modeIdx(logic [11:0] c);
    case (c)
      12'h101, 12'h686: return 0;
      12'h282: return 1;
      12'hB8B: return 2;
      12'h989: return 3;
      default: return -1;
    endcase
  endfunction
  function automatic int gHA(int i); int t[4] = '{640, 512, 640, 832};  return t[i] >> SH; endfunction
  function automatic int gHT(int i); int t[4] = '{864, 640, 800, 1072}; return t[i] >> SH; endfunction
  function automatic int gVA(int i); int t[4] = '{480, 384, 480, 624};  return t[i] >> SH; endfunction
  function automatic int gVT(int i); int t[4] = '{525, 407, 525, 690};  return t[i] >> SH; endfunction
  function automatic int gST(int i); int t[4] = '{80, 64, 80, 104};     return t[i]; endfunction

  task automatic finishRun();
    $display("Result: errors=%0d of %0d checks", nErr, nChecks);
    $finish;
  endtask

  task automatic chk(string req, longint act, longint exp);
    nChecks++;
    if (act != exp) begin
      nErr++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(int a, logic [31:0] d);
    addr = 5'(a); wrData = d; wrEn = 1'b1;
    @(posedge clk); @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic rd(int a, output logic [31:0] d);
    addr = 5'(a); #1; d = rdData;
  endtask

  function automatic longint elapsed(); return cyc - cycCommit; endfunction

  task automatic commit(logic [11:0] code, logic [31:0] key);
    wr('h00, {20'hFFFFF, code});
    wr('h0C, key);
    if (key[11:0] == 12'h101 && modeIdx(code) >= 0) begin
      curCode = code;
      cycCommit = cyc;
    end
  endtask

  task automatic checkRaster(string req);
    int i = modeIdx(curCode);
    longint pos = elapsed() % (gHT(i) * gVT(i));
    int eh = int'(pos % gHT(i));
    int ev = int'(pos / gHT(i));
    logic [31:0] d;
    chk({req, " hCount"}, hCount, eh);
    chk({req, " vCount"}, vCount, ev);
    chk({req, " R7 activeVideo"}, activeVideo, (curEn != 0 && eh < gHA(i) && ev < gVA(i)) ? 1 : 0);
    chk({req, " R8 pixDepth"}, pixDepth, curDepth);
    chk({req, " R8 lineStride"}, lineStride, gST(i) << curDepth);
    rd('h14, d);
    chk({req, " R9 vblank"}, d, (ev >= gVA(i)) ? 32'h0100_0000 : 0);
  endtask

  task automatic waitTo(longint target);
    while (elapsed() < target) @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 190000);
    nErr++;
    $display("FAIL watchdog: actual=running expected=done");
    finishRun();
  end

  initial begin
    logic [31:0] d;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    cycCommit = cyc;
    // R1 reset state
    chk("R1 hCount", hCount, 0);
    chk("R1 vCount", vCount, 0);
    chk("R1 activeVideo", activeVideo, 0);
    chk("R1 irq", irq, 0);
    chk("R1 pixDepth", pixDepth, 0);
    chk("R1 lineStride", lineStride, 80);
    repeat (37) @(negedge clk);
    checkRaster("R3 free run after reset");

    // R2 readback truncation
    wr('h00, 32'hFFFF_F989); rd('h00, d); chk("R2 select readback", d, 32'h989);
    wr('h04, 32'hFFFF_FFFC); rd('h04, d); chk("R2 depth readback", d, 4);
    curDepth = 4;
    wr('h10, 32'hABCD_E5A0); rd('h10, d); chk("R2 config readback", d, 32'h5A0);
    wr('h18, 32'h1234_5080); rd('h18, d); chk("R2 control readback", d, 32'h080);
    curEn = 1;
    rd('h0C, d); chk("R2 commit reads zero", d, 0);
    checkRaster("R8 depth 16bpp on default mode");

    // R4 key with junk upper bits commits; wrong key does not
    commit(12'h989, 32'hABCD_0101);
    checkRaster("R4 R5 commit wide mode");
    repeat (500) @(negedge clk);
    commit(12'h282, 32'h0000_0100);
    repeat (333) @(negedge clk);
    checkRaster("R4 wrong key ignored");
    // R6 unknown code
    commit(12'h123, 32'h101);
    repeat (211) @(negedge clk);
    checkRaster("R6 unknown code ignored");

    // R5 every code incl. 0x686, R8 every depth
    for (int k = 0; k < 5; k++) begin
      logic [11:0] codes[5] = '{12'h101, 12'h686, 12'h282, 12'hB8B, 12'h989};
      wr('h04, 32'(k)); curDepth = k;
      commit(codes[k], 32'h101);
      repeat (1000 + k * 917) @(negedge clk);
      checkRaster("R5 R8 mode sweep");
    end

    // R10/R11 interrupt, mode 0x282
    begin
      int i;
      wr('h10, 32'h1);
      commit(12'h282, 32'h101);
      i = modeIdx(12'h282);
      waitTo(longint'(gVA(i)) * gHT(i));
      chk("R10 irq low before blank entry", irq, 0);
      rd('h14, d); chk("R9 vblank at first blank line", d, 32'h0100_0000);
      @(negedge clk);
      chk("R10 irq set after blank entry", irq, 1);
      repeat (5) @(negedge clk);
      chk("R10 irq held", irq, 1);
      wr('h10, 32'h1);
      chk("R11 config write clears", irq, 0);
      // set beats clear on the same edge
      waitTo(longint'(gVT(i) + gVA(i)) * gHT(i));
      wr('h10, 32'h1);
      chk("R10 set wins over clear", irq, 1);
      wr('h10, 32'h0);
      chk("R11 clear with enable low", irq, 0);
      commit(12'h282, 32'h101);
      waitTo(longint'(gVA(i)) * gHT(i) + 4);
      chk("R10 disabled no irq", irq, 0);
      rd('h14, d); chk("R9 vblank while disabled", d, 32'h0100_0000);
    end

    // random mix
    for (int n = 0; n < 30; n++) begin
      logic [11:0] codes[5] = '{12'h101, 12'h686, 12'h282, 12'hB8B, 12'h989};
      logic [11:0] c = ($urandom_range(0, 5) == 5) ? 12'($urandom) : codes[$urandom_range(0, 4)];
      curDepth = $urandom_range(0, 4);
      curEn = $urandom_range(0, 1);
      wr('h04, 32'(curDepth));
      wr('h18, curEn ? 32'h80 : 32'h0);
      commit(c, ($urandom_range(0, 7) == 0) ? 32'h0000_0110 : 32'h0000_0101);
      repeat ($urandom_range(0, 3000)) @(negedge clk);
      checkRaster("R3 R7 random");
    end
    finishRun();
  end
endmodule